// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked system and a byte-wide asynchronous static RAM that has 20 address bits. It turns one request at a time into a timed sequence of select, read-enable and write-strobe levels. It holds the address steady for the whole access. It also decides when its own data driver may take the shared data lines. Every minimum and maximum time of the RAM is given as a nanosecond parameter. Each one is converted into a clock count by rounding up, and the defaults assume a 10 ns clock.

A client raises `req` with a direction bit, an address and, for a write, a byte of data. The controller samples the request only while it is idle. It returns a one-cycle `ready` pulse when the access completes, and for a read it also returns the captured byte on `rdata`. The RAM sees two select lines of opposite polarity. Its data lines are brought out as separate output, output-enable and input ports, so the surrounding pad logic resolves the bus.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, both selects are inactive (`sram_sel_n`=1, `sram_sel`=0), `sram_wstb_n`=1, `sram_rden_n`=1, `sram_dq_oe`=0 and `ready`=0.
- R2: The read-enable or the write strobe is active only while both selects are active.
- R3: A read drives `sram_rden_n` low from the accepting edge for RD_CYC = max(ceil(70/period), ceil(70/period)) = 7 cycles. It captures the input byte at the edge that ends that window, and `ready` is high in the cycle that follows, which is 7 edges after acceptance.
- R4: The write strobe stays low for exactly WE_LOW = max(ceil(35/period), ceil(30/period), ceil(70/period)-1) = 6 cycles. With no pending turnaround, `ready` follows WE_LOW+2 = 8 edges after acceptance.
- R5: `sram_addr` changes only while the write strobe is high. It is stable for at least ceil(70/period) = 7 cycles before the strobe rises.
- R6: `sram_dq_oe` is high, and `sram_dq_o` is unchanged, during every cycle in which the strobe is low. The driver turns off in the cycle after the strobe rises.
- R7: `sram_dq_oe` rises only after `sram_rden_n` has been high for at least TA = ceil(35/period) = 4 cycles. After a read, the write strobe therefore falls at the later of the edge after acceptance and the (TA+1)th edge after the read-enable rose.
- R8: `ready` is a single-cycle pulse, one per accepted request. A `req` raised while an access is in progress is ignored.
- R9: A read returns the byte most recently written to that address, or the initial content if the address was never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request, sampled only while idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Request address |
| req_wdata | input | 8 | Write byte |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Captured read byte |
| sram_addr | output | 20 | RAM address |
| sram_sel_n | output | 1 | Active-low select |
| sram_sel | output | 1 | Active-high select |
| sram_wstb_n | output | 1 | Active-low write strobe |
| sram_rden_n | output | 1 | Active-low read/output enable |
| sram_dq_o | output | 8 | Data toward RAM |
| sram_dq_oe | output | 1 | Data driver enable |
| sram_dq_i | input | 8 | Data from RAM |

## Verification
A read's `ready` is due exactly 7 edges after acceptance. A write's `ready` is due 8 edges after acceptance, plus max(0, TA-1-g) when it follows a read with g idle cycles in between. The bench predicts each latency from that formula and compares it, sampling on falling edges. The bench's RAM model returns the wrong byte until the address and read-enable have been stable for 7 cycles, so an early capture fails the data check. The model keeps driving the data lines for 3 cycles after the read-enable rises, which flags any driver overlap in the cycle where it happens.

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl #(
  parameter int CLK_NS  = 10,
  parameter int T_AA_NS = 70,
  parameter int T_RC_NS = 70,
  parameter int T_WP_NS = 35,
  parameter int T_AW_NS = 70,
  parameter int T_DW_NS = 30,
  parameter int T_HZ_NS = 35,
  parameter int AW      = 20,
  parameter int DW      = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ready,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] sram_addr,
  output logic          sram_sel_n,
  output logic          sram_sel,
  output logic          sram_wstb_n,
  output logic          sram_rden_n,
  output logic [DW-1:0] sram_dq_o,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_i
);
  localparam int C_AA   = (T_AA_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_RC   = (T_RC_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_WP   = (T_WP_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_AW   = (T_AW_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_DW   = (T_DW_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_HZ   = (T_HZ_NS + CLK_NS - 1) / CLK_NS;
  localparam int RD0    = C_AA > C_RC ? C_AA : C_RC;
  localparam int RD_CYC = RD0 > 1 ? RD0 : 1;
  localparam int WL0    = C_WP > C_DW ? C_WP : C_DW;
  localparam int WL1    = WL0 > C_AW - 1 ? WL0 : C_AW - 1;
  localparam int WE_LOW = WL1 > 1 ? WL1 : 1;
  localparam int TA     = C_HZ;
  localparam int MX0    = RD_CYC > WE_LOW ? RD_CYC : WE_LOW;
  localparam int MAXC   = MX0 > TA ? MX0 : TA;
  localparam int CNTW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WSET, S_WLOW, S_WREL} state_t;

  state_t          st;
  logic [CNTW-1:0] cnt;
  logic [CNTW-1:0] ohc;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wd_q;
  logic [DW-1:0]   rd_q;
  logic            sel_q;
  logic            wstb_n_q;
  logic            rden_n_q;
  logic            dq_oe_q;
  logic            ready_q;

  assign sram_addr   = addr_q;
  assign sram_sel    = sel_q;
  assign sram_sel_n  = ~sel_q;
  assign sram_wstb_n = wstb_n_q;
  assign sram_rden_n = rden_n_q;
  assign sram_dq_o   = wd_q;
  assign sram_dq_oe  = dq_oe_q;
  assign ready       = ready_q;
  assign rdata       = rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cnt      <= '0;
      ohc      <= '0;
      addr_q   <= '0;
      wd_q     <= '0;
      rd_q     <= '0;
      sel_q    <= 1'b0;
      wstb_n_q <= 1'b1;
      rden_n_q <= 1'b1;
      dq_oe_q  <= 1'b0;
      ready_q  <= 1'b0;
    end else begin
      ready_q <= 1'b0;
      if (!rden_n_q)                 ohc <= '0;
      else if (ohc != CNTW'(TA))     ohc <= ohc + 1'b1;
      case (st)
        S_IDLE: if (req) begin
          addr_q <= req_addr;
          wd_q   <= req_wdata;
          sel_q  <= 1'b1;
          if (req_wr) st <= S_WSET;
          else begin
            rden_n_q <= 1'b0;
            cnt      <= CNTW'(RD_CYC - 1);
            st       <= S_RD;
          end
        end
        S_RD: if (cnt == '0) begin
          rd_q     <= sram_dq_i;
          ready_q  <= 1'b1;
          rden_n_q <= 1'b1;
          sel_q    <= 1'b0;
          st       <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        S_WSET: if (ohc == CNTW'(TA)) begin
          dq_oe_q  <= 1'b1;
          wstb_n_q <= 1'b0;
          cnt      <= CNTW'(WE_LOW - 1);
          st       <= S_WLOW;
        end
        S_WLOW: if (cnt == '0) begin
          wstb_n_q <= 1'b1;
          st       <= S_WREL;
        end else cnt <= cnt - 1'b1;
        S_WREL: begin
          dq_oe_q <= 1'b0;
          sel_q   <= 1'b0;
          ready_q <= 1'b1;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module sram_ctrl_chk #(
  parameter int CLK_NS  = 10,
  parameter int T_AA_NS = 70,
  parameter int T_RC_NS = 70,
  parameter int T_WP_NS = 35,
  parameter int T_AW_NS = 70,
  parameter int T_DW_NS = 30,
  parameter int T_HZ_NS = 35,
  parameter int AW      = 20,
  parameter int DW      = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ready,
  input logic [AW-1:0] sram_addr,
  input logic          sram_sel_n,
  input logic          sram_sel,
  input logic          sram_wstb_n,
  input logic          sram_rden_n,
  input logic [DW-1:0] sram_dq_o,
  input logic          sram_dq_oe
);
  localparam int C_AA   = (T_AA_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_RC   = (T_RC_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_WP   = (T_WP_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_AW   = (T_AW_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_DW   = (T_DW_NS + CLK_NS - 1) / CLK_NS;
  localparam int TA     = (T_HZ_NS + CLK_NS - 1) / CLK_NS;
  localparam int RD0    = C_AA > C_RC ? C_AA : C_RC;
  localparam int RD_CYC = RD0 > 1 ? RD0 : 1;
  localparam int WL0    = C_WP > C_DW ? C_WP : C_DW;
  localparam int WL1    = WL0 > C_AW - 1 ? WL0 : C_AW - 1;
  localparam int WE_LOW = WL1 > 1 ? WL1 : 1;

  int wl_cnt, ol_cnt, oh_cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      wl_cnt <= 0; ol_cnt <= 0; oh_cnt <= 0;
    end else begin
      wl_cnt <= sram_wstb_n ? 0 : wl_cnt + 1;
      ol_cnt <= sram_rden_n ? 0 : ol_cnt + 1;
      oh_cnt <= !sram_rden_n ? 0 : (oh_cnt < TA ? oh_cnt + 1 : oh_cnt);
    end
  end

  a_r1_idle_after_reset: assert property (@(posedge clk)
    (!rst && $past(rst)) |-> (sram_sel_n && !sram_sel && sram_wstb_n && sram_rden_n && !sram_dq_oe && !ready));
  a_r2_strobe_needs_select: assert property (@(posedge clk) disable iff (rst)
    (!sram_wstb_n || !sram_rden_n) |-> (!sram_sel_n && sram_sel));
  a_r3_read_window: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_rden_n) |-> (ol_cnt == RD_CYC));
  a_r4_strobe_width: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_wstb_n) |-> (wl_cnt == WE_LOW));
  a_r5_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (!sram_wstb_n && !$past(sram_wstb_n)) |-> $stable(sram_addr));
  a_r6_drive_during_strobe: assert property (@(posedge clk) disable iff (rst)
    !sram_wstb_n |-> sram_dq_oe);
  a_r6_data_steady: assert property (@(posedge clk) disable iff (rst)
    (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_o));
  a_r7_turnaround: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_dq_oe) |-> (oh_cnt >= TA));
  a_r8_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);
endmodule

bind sram_ctrl sram_ctrl_chk #(
  .CLK_NS(CLK_NS), .T_AA_NS(T_AA_NS), .T_RC_NS(T_RC_NS), .T_WP_NS(T_WP_NS),
  .T_AW_NS(T_AW_NS), .T_DW_NS(T_DW_NS), .T_HZ_NS(T_HZ_NS), .AW(AW), .DW(DW)
) u_chk (
  .clk(clk), .rst(rst), .ready(ready), .sram_addr(sram_addr),
  .sram_sel_n(sram_sel_n), .sram_sel(sram_sel), .sram_wstb_n(sram_wstb_n),
  .sram_rden_n(sram_rden_n), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe)
);

// File: tb/sram_ctrl_bench.sv
`timescale 1ns/1ps
module sram_ctrl_bench;
  localparam int RD_CYC = 7;
  localparam int WE_LOW = 6;
  localparam int TA     = 4;
  localparam int C_WP   = 4;
  localparam int C_DW   = 3;
  localparam int C_AW   = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, req_wr = 1'b0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic ready;
  logic [7:0] rdata;
  logic [19:0] sram_addr;
  logic sram_sel_n, sram_sel, sram_wstb_n, sram_rden_n, sram_dq_oe;
  logic [7:0] sram_dq_o;
  logic [7:0] sram_dq_i = 8'h00;

  always #5 clk = ~clk;

  sram_ctrl u_sram_ctrl (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .ready(ready), .rdata(rdata), .sram_addr(sram_addr),
    .sram_sel_n(sram_sel_n), .sram_sel(sram_sel), .sram_wstb_n(sram_wstb_n),
    .sram_rden_n(sram_rden_n), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe),
    .sram_dq_i(sram_dq_i)
  );

  int n_chk = 0, n_fail = 0;
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] init_val(input logic [19:0] a);
    return a[7:0] ^ a[19:12] ^ 8'h3C;
  endfunction

  // RAM model
  logic [7:0] mem [int];
  logic [7:0] ref_mem [int];
  function automatic logic [7:0] mget(input logic [19:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : init_val(a);
  endfunction
  function automatic logic [7:0] rget(input logic [19:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_val(a);
  endfunction

  logic [19:0] p_addr = '0;
  logic [7:0]  p_dq = '0;
  bit p_rd = 0, p_wr = 0;
  int rd_cnt = 0, hold = 0, wl_cnt = 0, dst = 0, ast = 0, p_ast = 0;
  always @(negedge clk) begin
    bit sel, rd_act, wr_act;
    sel    = !sram_sel_n && sram_sel;
    rd_act = sel && !sram_rden_n && sram_wstb_n;
    wr_act = sel && !sram_wstb_n;
    if (rd_act && p_rd && sram_addr == p_addr) rd_cnt++; else rd_cnt = rd_act ? 1 : 0;
    if (rd_act) hold = 4; else if (hold > 0) hold--;
    if (sram_dq_oe && (rd_act || hold > 0)) check(0, "R7 bus overlap", 1, 0);
    sram_dq_i <= rd_act ? (rd_cnt >= RD_CYC ? mget(sram_addr) : ~mget(sram_addr)) : 8'h5A;
    ast = (sram_addr == p_addr) ? ast + 1 : 1;
    if (wr_act) begin
      if (p_wr && sram_addr != p_addr) check(0, "R5 addr moved", sram_addr, p_addr);
      if (!sram_dq_oe) check(0, "R6 not driven", 0, 1);
      wl_cnt = p_wr ? wl_cnt + 1 : 1;
      dst = (p_wr && sram_dq_o == p_dq) ? dst + 1 : 1;
    end else if (p_wr) begin
      mem[int'(p_addr)] = p_dq;
      check(wl_cnt >= C_WP, "R4 pulse width", wl_cnt, C_WP);
      check(dst >= C_DW, "R6 data setup", dst, C_DW);
      check(p_ast >= C_AW, "R5 addr setup", p_ast, C_AW);
    end
    p_rd = rd_act; p_wr = wr_act; p_addr = sram_addr; p_dq = sram_dq_o; p_ast = ast;
  end

  bit last_rd = 0;
  int gap = 0;
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    gap += n;
  endtask

  task automatic run_op(input bit wr, input logic [19:0] a, input logic [7:0] d);
    int lat, exp_lat, extra;
    extra   = (last_rd && wr && (TA - 1 - gap) > 0) ? TA - 1 - gap : 0;
    exp_lat = wr ? WE_LOW + 2 + extra : RD_CYC;
    req = 1; req_wr = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 0;
    lat = 0;
    while (!ready && lat < 100) begin @(negedge clk); lat++; end
    if (wr) begin
      check(lat == exp_lat, "R4/R7 write latency", lat, exp_lat);
      ref_mem[int'(a)] = d;
    end else begin
      check(lat == exp_lat, "R3 read latency", lat, exp_lat);
      check(rdata == rget(a), "R9 read data", rdata, rget(a));
    end
    @(negedge clk);
    check(!ready, "R8 single pulse", ready, 0);
    last_rd = !wr;
    gap = 1;
  endtask

  initial begin
    #(200000 * 10);
    check(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [19:0] pool [8];
    void'($urandom(32'h5EED));
    pool[0] = 20'h00000; pool[1] = 20'hFFFFF; pool[2] = 20'h12345; pool[3] = 20'h80000;
    pool[4] = 20'h00001; pool[5] = 20'h7FFFF; pool[6] = 20'hABCDE; pool[7] = 20'h0F0F0;
    repeat (3) @(negedge clk);
    check(sram_sel_n && !sram_sel && sram_wstb_n && sram_rden_n && !sram_dq_oe && !ready,
          "R1 in reset", {sram_sel_n, sram_sel, sram_wstb_n, sram_rden_n, sram_dq_oe, ready}, 6'b101100);
    req = 1; req_wr = 1; req_addr = 20'h00042;
    @(negedge clk);
    rst = 0; req = 0;
    @(negedge clk);
    check(sram_sel_n && !sram_sel && sram_wstb_n && sram_rden_n && !sram_dq_oe && !ready,
          "R1 after reset", {sram_sel_n, sram_sel, sram_wstb_n, sram_rden_n, sram_dq_oe, ready}, 6'b101100);
    idle(TA + 4);

    // directed corners
    run_op(0, 20'h00000, 0);
    run_op(1, 20'h00000, 8'hA5);
    run_op(0, 20'h00000, 0);
    run_op(1, 20'hFFFFF, 8'h00);
    run_op(1, 20'hFFFFF, 8'hFF);
    run_op(0, 20'hFFFFF, 0);
    run_op(1, 20'h12345, 8'h5A);   // write right after a read: R7 turnaround
    run_op(0, 20'h55555, 0);        // unwritten: R9
    idle(2);
    run_op(1, 20'h00001, 8'h3C);    // after read with longer gap

    // R8: request raised mid-access is ignored
    begin
      int pulses;
      req = 1; req_wr = 1; req_addr = 20'h0AAAA; req_wdata = 8'h77;
      @(posedge clk); @(negedge clk);
      req = 0;
      @(negedge clk);
      req = 1; req_wr = 1; req_addr = 20'h0BBBB; req_wdata = 8'h99;
      @(negedge clk);
      req = 0;
      pulses = 0;
      repeat (25) begin @(negedge clk); if (ready) pulses++; end
      check(pulses == 1, "R8 busy request ignored", pulses, 1);
      ref_mem[int'(20'h0AAAA)] = 8'h77;
      last_rd = 0; gap = 25;
    end
    run_op(0, 20'h0BBBB, 0);
    run_op(0, 20'h0AAAA, 0);

    // constrained random
    for (int i = 0; i < 120; i++) begin
      logic [19:0] a;
      bit wr;
      wr = $urandom_range(0, 1) == 1;
      a = ($urandom_range(0, 3) == 0) ? 20'($urandom()) : pool[$urandom_range(0, 7)];
      run_op(wr, a, 8'($urandom()));
      if ($urandom_range(0, 2) == 0) idle($urandom_range(0, 3));
    end
    for (int i = 0; i < 8; i++) run_op(0, pool[i], 0);

    idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule